// File: doc/BRIEF.md
# Serial Front-End Control Expander

This block receives a 48-bit configuration frame over a three-wire serial link (clock, data, active-low select) and spreads it across eight analog channels. Each channel has a 2-bit selector for its four-way input switch (zero, positive single-ended, negative single-ended, differential) and a 2-bit gain code for its programmable amplifier. The serial wires are synchronised into the system clock domain, and the serial clock is oversampled there. A frame is applied only when the select line is released after exactly 48 bits. When a frame is applied, all amplifiers get an active-low latch strobe so that they capture the new gain code and then hold it.

The control path is a small state machine with three states. ST_IDLE waits for a frame. ST_SETTLE lasts one clock, during which the new codes reach the pins. ST_STROBE holds every latch strobe low for two clocks. The transitions are: IDLE→SETTLE when a frame is accepted; SETTLE→STROBE always; STROBE→IDLE when the strobe count is reached; and any state→SETTLE when another frame is accepted. A frame of the wrong length is dropped, and it raises an error flag that stays set until the next good frame.

Top module: `cfg_fanout_rx`

## Requirements
- R1: While and after reset, all mode outputs are 00 (zero input), all gain outputs are 00 (lowest gain), every latch strobe is high and the error flag is 0.
- R2: A frame is sampled on rising `sclk_i` edges while `sel_n_i` is low, most significant bit first, so frame bit 47 arrives first. Channel c uses frame bits [6c+5:6c]. Bits [6c+5:6c+4] drive `mode_o[2c+1:2c]` and bits [6c+3:6c+2] drive `gain_o[2c+1:2c]`.
- R3: The mode and gain outputs do not change while `sel_n_i` is held low.
- R4: When `sel_n_i` rises after exactly 48 bits, the new codes appear on the outputs at the third rising system clock edge after the rise.
- R5: When `sel_n_i` rises after any other bit count (0, 47 or 49, for example), the outputs keep their values, no strobe is issued and `rx_err_o` becomes 1.
- R6: `rx_err_o` returns to 0 at the same edge where the next good frame is applied.
- R7: After a frame is accepted, all eight `latch_n_o` bits go low together for exactly two system clocks. They go low one clock after the new codes appear, and this happens even when the codes are unchanged.
- R8: Frame bits [6c+1:6c] are spare bits and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial link clock (asynchronous, oversampled) |
| sdat_i | input | 1 | Serial link data |
| sel_n_i | input | 1 | Active-low frame select |
| mode_o | output | 16 | Input-switch code, 2 bits per channel |
| gain_o | output | 16 | Amplifier gain code, 2 bits per channel |
| latch_n_o | output | 8 | Active-low gain latch strobe per channel |
| rx_err_o | output | 1 | Last frame had the wrong length |

## Verification
The hardest case to reach from the ports is the release of the select line at an exact bit count that is one off from a full frame. The driver reaches it with a length argument and sends 47-bit, 49-bit and zero-bit frames between good ones. The bench checks that the pins keep the earlier codes, that no strobe appears and that the flag clears only on the next good frame. A good frame that differs only in its spare bits is used to show that the strobe still fires while the codes stay the same.

// File: rtl/cfg_fanout_pkg.sv
package cfg_fanout_pkg;
    localparam int FO_NUM_CH  = 8;
    localparam int FO_SLOT_W  = 6;
    localparam int FO_MODE_W  = 2;
    localparam int FO_GAIN_W  = 2;
    localparam int FO_STROBE  = 2;
    localparam int FO_SYNC    = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_STROBE = 2'd2
    } fo_state_e;
endpackage

// File: rtl/cfg_fanout_sync.sv
module cfg_fanout_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[g] <= RST_VAL;
            end else if (g == 0) begin
                stg[g] <= d_i;
            end else begin
                stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_fanout_shifter.sv
module cfg_fanout_shifter #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdat_s,
    input  logic               sel_n_s,
    output logic [FRAME_W-1:0] frame_o,
    output logic               frame_ok_o,
    output logic               frame_bad_o
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W);

    logic               sclk_q, sel_n_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               sclk_rise, sel_fall, sel_rise;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sel_fall  = ~sel_n_s & sel_n_q;
    assign sel_rise  = sel_n_s & ~sel_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sel_n_q <= 1'b1;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else begin
            sclk_q  <= sclk_s;
            sel_n_q <= sel_n_s;
            if (sel_fall) begin
                cnt_q <= '0;
            end else if (!sel_n_s && sclk_rise) begin
                shreg_q <= {shreg_q[FRAME_W-2:0], sdat_s};
                if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign frame_o     = shreg_q;
    assign frame_ok_o  = sel_rise & (cnt_q == CNT_GOOD);
    assign frame_bad_o = sel_rise & (cnt_q != CNT_GOOD);
endmodule

// File: rtl/cfg_fanout_ctrl.sv
module cfg_fanout_ctrl
    import cfg_fanout_pkg::*;
#(
    parameter int NUM_CH     = FO_NUM_CH,
    parameter int SLOT_W     = FO_SLOT_W,
    parameter int MODE_W     = FO_MODE_W,
    parameter int GAIN_W     = FO_GAIN_W,
    parameter int STROBE_LEN = FO_STROBE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*SLOT_W-1:0] frame_i,
    input  logic                     frame_ok_i,
    input  logic                     frame_bad_i,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [NUM_CH*GAIN_W-1:0] gain_o,
    output logic [NUM_CH-1:0]        latch_n_o,
    output logic                     rx_err_o
);
    localparam int MODE_LSB = SLOT_W - MODE_W;
    localparam int GAIN_LSB = MODE_LSB - GAIN_W;
    localparam int STB_W    = (STROBE_LEN > 1) ? $clog2(STROBE_LEN) : 1;
    localparam logic [STB_W-1:0] STB_LAST = STB_W'(STROBE_LEN - 1);

    fo_state_e                state_q, state_nx;
    logic [STB_W-1:0]         stb_cnt_q;
    logic [NUM_CH*MODE_W-1:0] mode_nx, mode_q;
    logic [NUM_CH*GAIN_W-1:0] gain_nx, gain_q;
    logic                     err_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
        assign mode_nx[ch*MODE_W +: MODE_W] = frame_i[ch*SLOT_W + MODE_LSB +: MODE_W];
        assign gain_nx[ch*GAIN_W +: GAIN_W] = frame_i[ch*SLOT_W + GAIN_LSB +: GAIN_W];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            stb_cnt_q <= '0;
        end else begin
            state_q   <= state_nx;
            stb_cnt_q <= (state_q == ST_STROBE) ? stb_cnt_q + 1'b1 : '0;
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   state_nx = ST_IDLE;
            ST_SETTLE: state_nx = ST_STROBE;
            ST_STROBE: if (stb_cnt_q == STB_LAST) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
        if (frame_ok_i) begin
            state_nx = ST_SETTLE;
        end
    end

    // output process
    always_comb begin
        latch_n_o = (state_q == ST_STROBE) ? '0 : '1;
    end

    // code registers and length flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            gain_q <= '0;
            err_q  <= 1'b0;
        end else if (frame_ok_i) begin
            mode_q <= mode_nx;
            gain_q <= gain_nx;
            err_q  <= 1'b0;
        end else if (frame_bad_i) begin
            err_q  <= 1'b1;
        end
    end

    assign mode_o   = mode_q;
    assign gain_o   = gain_q;
    assign rx_err_o = err_q;
endmodule

// File: rtl/cfg_fanout_rx.sv
module cfg_fanout_rx
    import cfg_fanout_pkg::*;
#(
    parameter int NUM_CH      = FO_NUM_CH,
    parameter int SLOT_W      = FO_SLOT_W,
    parameter int MODE_W      = FO_MODE_W,
    parameter int GAIN_W      = FO_GAIN_W,
    parameter int STROBE_LEN  = FO_STROBE,
    parameter int SYNC_STAGES = FO_SYNC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_i,
    input  logic                     sdat_i,
    input  logic                     sel_n_i,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [NUM_CH*GAIN_W-1:0] gain_o,
    output logic [NUM_CH-1:0]        latch_n_o,
    output logic                     rx_err_o
);
    localparam int FRAME_W = NUM_CH * SLOT_W;

    logic [2:0]         wires_s;
    logic [FRAME_W-1:0] frame;
    logic               frame_ok, frame_bad;

    cfg_fanout_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sel_n_i, sdat_i, sclk_i}),
        .q_o  (wires_s)
    );

    cfg_fanout_shifter #(
        .FRAME_W(FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (wires_s[0]),
        .sdat_s     (wires_s[1]),
        .sel_n_s    (wires_s[2]),
        .frame_o    (frame),
        .frame_ok_o (frame_ok),
        .frame_bad_o(frame_bad)
    );

    cfg_fanout_ctrl #(
        .NUM_CH    (NUM_CH),
        .SLOT_W    (SLOT_W),
        .MODE_W    (MODE_W),
        .GAIN_W    (GAIN_W),
        .STROBE_LEN(STROBE_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame),
        .frame_ok_i (frame_ok),
        .frame_bad_i(frame_bad),
        .mode_o     (mode_o),
        .gain_o     (gain_o),
        .latch_n_o  (latch_n_o),
        .rx_err_o   (rx_err_o)
    );
endmodule

// File: rtl/cfg_fanout_rx_chk.sv
module cfg_fanout_rx_chk #(
    parameter int NUM_CH = 8,
    parameter int MODE_W = 2,
    parameter int GAIN_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sel_n_i,
    input logic [NUM_CH*MODE_W-1:0] mode_o,
    input logic [NUM_CH*GAIN_W-1:0] gain_o,
    input logic [NUM_CH-1:0]        latch_n_o,
    input logic                     rx_err_o
);
    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_STATE: assert (mode_o == '0 && gain_o == '0 && latch_n_o == '1 && !rx_err_o); // R1
        end
    end

    AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_i && !$past(sel_n_i) && !$past(sel_n_i, 2) && !$past(sel_n_i, 3))
        |-> ($stable(mode_o) && $stable(gain_o))); // R3

    AST_BAD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_err_o) |-> ($stable(mode_o) && $stable(gain_o))); // R5

    AST_ERR_CLEAR_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_err_o) |=> (latch_n_o == '0)); // R6

    AST_STROBE_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_n_o == '0) || (latch_n_o == '1)); // R7

    AST_STROBE_AFTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_o) || !$stable(gain_o)) |=> (latch_n_o == '0)); // R7

    AST_STROBE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_n_o[0]) |=> !latch_n_o[0]); // R7

    AST_STROBE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_n_o[0] && !$past(latch_n_o[0])) |=> latch_n_o[0]); // R7
endmodule

bind cfg_fanout_rx cfg_fanout_rx_chk #(
    .NUM_CH(NUM_CH),
    .MODE_W(MODE_W),
    .GAIN_W(GAIN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n_i  (sel_n_i),
    .mode_o   (mode_o),
    .gain_o   (gain_o),
    .latch_n_o(latch_n_o),
    .rx_err_o (rx_err_o)
);

// File: tb/cfg_fanout_rx_bench.sv
module cfg_fanout_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0;
    logic        sdat_i = 1'b0;
    logic        sel_n_i = 1'b1;
    logic [15:0] mode_o, gain_o;
    logic [7:0]  latch_n_o;
    logic        rx_err_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] mode;
        logic [15:0] gain;
        logic        err;
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];

    logic [15:0] exp_mode = '0, exp_gain = '0;
    logic        exp_err = 1'b0;

    always #10 clk = ~clk;

    cfg_fanout_rx u_cfg_fanout_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (sclk_i),
        .sdat_i   (sdat_i),
        .sel_n_i  (sel_n_i),
        .mode_o   (mode_o),
        .gain_o   (gain_o),
        .latch_n_o(latch_n_o),
        .rx_err_o (rx_err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // R2: channel c slot at [6c+5:6c] = {mode, gain, spare}
    function automatic logic [47:0] build(input logic [15:0] m, input logic [15:0] g,
                                          input logic [15:0] sp);
        logic [47:0] f;
        for (int c = 0; c < 8; c++) begin
            f[6*c+4 +: 2] = m[2*c +: 2];
            f[6*c+2 +: 2] = g[2*c +: 2];
            f[6*c   +: 2] = sp[2*c +: 2];
        end
        return f;
    endfunction

    // monitor: pops expected items and compares against the pins
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(mode_o == it.mode, it.req, "mode", 32'(mode_o), 32'(it.mode));
                check(gain_o == it.gain, it.req, "gain", 32'(gain_o), 32'(it.gain));
                check(rx_err_o == it.err, it.req, "rx_err", 32'(rx_err_o), 32'(it.err));
            end
        end
    end

    task automatic send(input logic [47:0] f, input int nbits, input bit good,
                        input string req);
        logic [15:0] old_m, old_g, new_m, new_g;
        logic [15:0] sm [13];
        logic [15:0] sg [13];
        logic [7:0]  sl [13];
        int first_low, lows, moved;
        sb_item_t it;
        old_m = exp_mode;
        old_g = exp_gain;
        moved = 0;
        @(negedge clk);
        sel_n_i = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdat_i = (i < 48) ? f[47-i] : 1'b0;
            repeat (3) @(negedge clk);
            sclk_i = 1'b1;
            repeat (3) @(negedge clk);
            sclk_i = 1'b0;
            if (mode_o != old_m || gain_o != old_g) moved++;
        end
        repeat (4) @(negedge clk);
        check(moved == 0, "R3", "outputs moved while selected", 32'(moved), 0);
        sel_n_i = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            sm[k] = mode_o;
            sg[k] = gain_o;
            sl[k] = latch_n_o;
        end
        if (good) begin
            exp_mode = 16'h0;
            exp_gain = 16'h0;
            for (int c = 0; c < 8; c++) begin
                exp_mode[2*c +: 2] = f[6*c+4 +: 2];
                exp_gain[2*c +: 2] = f[6*c+2 +: 2];
            end
            exp_err = 1'b0;
        end else begin
            exp_err = 1'b1;
        end
        new_m = exp_mode;
        new_g = exp_gain;
        first_low = 0;
        lows = 0;
        for (int k = 1; k <= 12; k++) begin
            if (sl[k] != 8'hFF) begin
                lows++;
                if (first_low == 0) first_low = k;
            end
        end
        if (good) begin
            // R4: applied at third edge after release; R7: strobe follows one clock later
            check(sm[3] == new_m && sg[3] == new_g, "R4", "codes at third edge",
                  {sm[3], sg[3]}, {new_m, new_g});
            check(first_low == 4 && lows == 2 && sl[4] == 8'h00 && sl[5] == 8'h00,
                  "R7", "strobe start/length", 32'(first_low * 16 + lows), 32'(4 * 16 + 2));
            if (old_m != new_m || old_g != new_g)
                check(sm[2] == old_m && sg[2] == old_g, "R4", "codes early",
                      {sm[2], sg[2]}, {old_m, old_g});
        end else begin
            check(lows == 0, "R5", "strobe on discarded frame", 32'(lows), 0);
        end
        it.mode = new_m;
        it.gain = new_g;
        it.err  = exp_err;
        it.req  = req;
        sb_q.push_back(it);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(mode_o == '0 && gain_o == '0, "R1", "codes in reset", {mode_o, gain_o}, 0);
        check(latch_n_o == 8'hFF && !rx_err_o, "R1", "strobe/flag in reset",
              {23'd0, rx_err_o, latch_n_o}, 32'hFF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mode_o == '0 && gain_o == '0 && latch_n_o == 8'hFF, "R1", "after reset",
              {mode_o, gain_o}, 0);

        send(build(16'hE41B, 16'h1E72, 16'h0000), 48, 1'b1, "R2");
        send(build(16'h5AC3, 16'hB08D, 16'hFFFF), 48, 1'b1, "R8");
        send(build(16'hFFFF, 16'hFFFF, 16'h0000), 47, 1'b0, "R5");
        send(build(16'h0F0F, 16'h3C3C, 16'h1234), 48, 1'b1, "R6");
        send(build(16'hAAAA, 16'h5555, 16'h0000), 49, 1'b0, "R5");
        send(48'h0, 0, 1'b0, "R5");
        send(build(16'h9C63, 16'h4E21, 16'h0000), 48, 1'b1, "R6");
        // same codes, different spare bits: codes unchanged, strobe still issued
        send(build(16'h9C63, 16'h4E21, 16'hA5F0), 48, 1'b1, "R8");
        send(build(16'hFFFF, 16'hFFFF, 16'hFFFF), 48, 1'b1, "R2");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R2", "scoreboard drained", 32'(sb_q.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule